// File: doc/BRIEF.md
# Timer and Event Counter with Single-Shot Pulse Capture

An 8-bit up-counter that sits behind a small register write port and serves three jobs. It can tick on a prescaled internal clock, or count active edges arriving on an external pin. In its third job it measures the width of a single pulse on that pin. A preload register supplies the reload value after every wrap and also seeds the counter whenever software writes it while the counter is idle.

The control register holds five fields. Bits 7:6 are the mode: 00 idle, 01 edge counting, 10 internal timer, 11 pulse capture. Bit 4 is the enable and bit 3 is the polarity. Bits 2:0 hold a prescale exponent n, so the internal tick is divided by 2^n. A two-bit source input picks the internal tick. Value 00 uses every system clock, 01 uses every fourth system clock, and 10 or 11 uses a strobe from a slow clock domain that has already been synchronised. The pin passes through two synchroniser flops and an edge detector before any logic uses it.

In capture mode, setting the enable only arms the block. Counting begins on the start edge, which is falling when polarity is 0 and rising when it is 1. Counting stops when the pin returns to its idle level, and at that moment hardware clears the enable. The result then stays frozen until software arms the block again. Each wrap is reported on a one-cycle interrupt output, and in edge-counting mode also on a wake-up output.

Top module: `tmr_event_capture`

## Requirements
- R1: After synchronous reset, the control register, the counter, irq and wake all read zero.
- R2: A preload write (wr_sel=1) loads the counter when the enable (bit 4) is 0 or the mode (bits 7:6) is 00. In mode 00 the counter does not change for any other reason.
- R3: In timer mode (10) with enable set, the counter advances once every 2^n internal ticks, where n is bits 2:0. The prescaler restarts from zero whenever counting is not in progress. So N clocks after the enabling write, with source 00, the count has risen by floor(N/2^n).
- R4: Source select 01 gives one internal tick every fourth clock, counted from the start of counting. Source select 10 gives one tick per slow_tick strobe.
- R5: In edge mode (01) with enable set, the counter advances once per pin edge of the chosen polarity: rising when bit 3 is 1, falling when bit 3 is 0. Edges of the other polarity are not counted.
- R6: In capture mode (11) with bit 3 at 0, counting starts on a falling pin edge and runs on prescaled ticks until the pin goes high again. With source 00 and n=0, a low pulse that lasts W clocks adds exactly W to the counter.
- R7: In capture mode with bit 3 at 1, the same holds for a high pulse bounded by a rising edge and a falling edge.
- R8: In capture mode, hardware clears enable bit 4 at the end of the pulse. In edge and timer modes, only a control write changes bit 4.
- R9: Once the enable has cleared itself, further pin pulses leave the counter unchanged.
- R10: On an advance from 0xFF, the counter takes the preload value and counting continues.
- R11: irq pulses for one cycle, in the cycle after the wrap, only when int_en was high at the wrap.
- R12: wake pulses on every wrap in edge mode whatever int_en is. It never pulses in the other modes.
- R13: A preload write while the counter is running changes only the reload value and leaves the current count alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = preload register |
| wr_data | input | 8 | Write data |
| clk_src | input | 2 | Internal tick source: 00 clock, 01 clock/4, 1x slow strobe |
| slow_tick | input | 1 | One-cycle strobe from the slow clock |
| tmr_pin | input | 1 | External timer pin (asynchronous) |
| int_en | input | 1 | Interrupt enable |
| ctrl_q | output | 8 | Control register readback |
| count_q | output | 8 | Counter readback |
| irq | output | 1 | One-cycle overflow interrupt |
| wake | output | 1 | One-cycle wake-up request on overflow in edge mode |

## Verification
Pulse widths are checked in both polarities, with and without a prescaler, and include a one-clock pulse and a pulse long enough to wrap. A design that is off by one on where counting starts or stops would return W-1 or W+1. A design that ignores the end edge would keep counting. After each capture the pin is pulsed again: a block that does not truly disarm would add those pulses to the frozen result. The bench also checks that edges of the wrong polarity are not counted. It checks that wrapping with int_en low still raises wake in edge mode, and that a timer-mode wrap never does. Finally, it checks that a preload write during counting does not overwrite the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_PSC_BITS = 3;
    localparam int TMR_PDIV_W   = (1 << TMR_PSC_BITS) - 1;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'b00,
        MODE_EVENT   = 2'b01,
        MODE_TIMER   = 2'b10,
        MODE_CAPTURE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        SRC_CLK   = 2'b00,
        SRC_CLK4  = 2'b01,
        SRC_SLOW  = 2'b10,
        SRC_SLOW2 = 2'b11
    } tmr_src_e;

    typedef struct packed {
        tmr_mode_e                 mode;
        logic                      spare;
        logic                      enable;
        logic                      pol_hi;
        logic [TMR_PSC_BITS-1:0]   psc;
    } tmr_ctrl_t;

    // Low n bits set: the prescaler fires when these bits are all ones.
    function automatic logic [TMR_PDIV_W-1:0] psc_mask(input logic [TMR_PSC_BITS-1:0] n);
        logic [TMR_PDIV_W-1:0] m;
        for (int i = 0; i < TMR_PDIV_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
    assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic [1:0]              src_sel,
    input  logic                    slow_tick,
    input  logic [TMR_PSC_BITS-1:0] psc_sel,
    output logic                    tick_o
);
    logic [1:0]            div4_q;
    logic [TMR_PDIV_W-1:0] pcnt_q;
    logic                  base_tick;
    logic [TMR_PDIV_W-1:0] mask;

    always_comb begin
        unique case (tmr_src_e'(src_sel))
            SRC_CLK:  base_tick = 1'b1;
            SRC_CLK4: base_tick = (div4_q == 2'd3);
            default:  base_tick = slow_tick;
        endcase
    end

    assign mask   = psc_mask(psc_sel);
    assign tick_o = base_tick & ((pcnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div4_q <= '0;
            pcnt_q <= '0;
        end else begin
            div4_q <= div4_q + 2'd1;
            if (base_tick) pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pre_we,
    input  logic [W-1:0] pre_wdata,
    input  logic         idle,
    input  logic         step,
    output logic [W-1:0] count_o,
    output logic [W-1:0] preload_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] count_q;
    logic [W-1:0] preload_q;

    assign wrap_o    = step && (count_q == CNT_MAX);
    assign count_o   = count_q;
    assign preload_o = preload_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            preload_q <= '0;
        end else begin
            if (pre_we) preload_q <= pre_wdata;
            if (pre_we && idle)  count_q <= pre_wdata;
            else if (wrap_o)     count_q <= preload_q;
            else if (step)       count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_event_capture.sv
module tmr_event_capture
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [1:0]       clk_src,
    input  logic             slow_tick,
    input  logic             tmr_pin,
    input  logic             int_en,
    output logic [7:0]       ctrl_q,
    output logic [CNT_W-1:0] count_q,
    output logic             irq,
    output logic             wake
);
    tmr_ctrl_t        ctrl_r;
    logic             measuring_q;
    logic             pin_rise, pin_fall;
    logic             start_edge, end_edge;
    logic             pre_tick;
    logic             running, idle, step, wrap;
    logic             wr_ctrl, wr_pre;
    logic             cap_mode;
    logic [CNT_W-1:0] preload_q;
    logic             irq_q, wake_q;

    assign wr_ctrl  = wr_en && !wr_sel;
    assign wr_pre   = wr_en &&  wr_sel;
    assign cap_mode = ctrl_r.enable && (ctrl_r.mode == MODE_CAPTURE);

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (tmr_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    // Polarity 1: rising edge is the active/start edge; polarity 0: falling.
    assign start_edge = ctrl_r.pol_hi ? pin_rise : pin_fall;
    assign end_edge   = ctrl_r.pol_hi ? pin_fall : pin_rise;

    assign running = ctrl_r.enable &&
                     ((ctrl_r.mode == MODE_TIMER) ||
                      ((ctrl_r.mode == MODE_CAPTURE) && measuring_q));
    assign idle    = !ctrl_r.enable || (ctrl_r.mode == MODE_IDLE);

    tmr_prescaler u_psc (
        .clk       (clk),
        .rst       (rst),
        .clear     (!running),
        .src_sel   (clk_src),
        .slow_tick (slow_tick),
        .psc_sel   (ctrl_r.psc),
        .tick_o    (pre_tick)
    );

    always_comb begin
        step = 1'b0;
        if (ctrl_r.enable) begin
            unique case (ctrl_r.mode)
                MODE_EVENT:   step = start_edge;
                MODE_TIMER:   step = pre_tick;
                MODE_CAPTURE: step = measuring_q && pre_tick;
                default:      step = 1'b0;
            endcase
        end
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .pre_we    (wr_pre),
        .pre_wdata (wr_data[CNT_W-1:0]),
        .idle      (idle),
        .step      (step),
        .count_o   (count_q),
        .preload_o (preload_q),
        .wrap_o    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r      <= '0;
            measuring_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_r      <= tmr_ctrl_t'(wr_data);
            measuring_q <= 1'b0;
        end else if (!cap_mode) begin
            measuring_q <= 1'b0;
        end else if (!measuring_q && start_edge) begin
            measuring_q <= 1'b1;
        end else if (measuring_q && end_edge) begin
            measuring_q   <= 1'b0;
            ctrl_r.enable <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            irq_q  <= wrap && int_en;
            wake_q <= wrap && (ctrl_r.mode == MODE_EVENT);
        end
    end

    assign ctrl_q = ctrl_r;
    assign irq    = irq_q;
    assign wake   = wake_q;
endmodule

// File: rtl/tmr_event_capture_chk.sv
module tmr_event_capture_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             int_en,
    input logic [7:0]       ctrl_q,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] preload,
    input logic             irq,
    input logic             wake
);
    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(int_en));

    // R12
    wake_mode_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> ($past(ctrl_q[7:6]) == 2'b01));

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl_q[4]) && !$past(wr_en)) |-> $stable(count_q));

    // R8
    autoclear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(ctrl_q[4]) && !$past(wr_en)) |-> ($past(ctrl_q[7:6]) == 2'b11));

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq || wake) && !$past(wr_en)) |-> (count_q == preload));
endmodule

bind tmr_event_capture tmr_event_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .int_en  (int_en),
    .ctrl_q  (ctrl_q),
    .count_q (count_q),
    .preload (preload_q),
    .irq     (irq),
    .wake    (wake)
);

// File: tb/sim_tmr_event_capture.sv
`timescale 1ns/1ps
module sim_tmr_event_capture;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] clk_src = 2'b00;
    logic       slow_tick = 1'b0, tmr_pin = 1'b0, int_en = 1'b0;
    logic [7:0] ctrl_q, count_q;
    logic       irq, wake;

    int checks = 0, errors = 0, irq_seen = 0, wake_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_event_capture u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .clk_src(clk_src), .slow_tick(slow_tick), .tmr_pin(tmr_pin), .int_en(int_en),
        .ctrl_q(ctrl_q), .count_q(count_q), .irq(irq), .wake(wake)
    );

    always @(negedge clk) begin
        if (!rst && irq)  irq_seen++;
        if (!rst && wake) wake_seen++;
    end

    // {polarity nibble, prescale nibble, width byte, preload byte}
    localparam logic [23:0] CAP_VEC [6] = '{
        24'h00_05_00, 24'h10_09_10, 24'h00_14_F0,
        24'h11_0A_30, 24'h00_01_7F, 24'h10_0C_FF
    };

    function automatic logic [7:0] model(input logic [7:0] p, input int n);
        logic [7:0] v = p;
        for (int i = 0; i < n; i++) v = (v == 8'hFF) ? p : v + 8'd1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // caller stands at a negedge; write lands on the following posedge
    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n, input logic active);
        for (int i = 0; i < n; i++) begin
            tmr_pin = active;  idle_n(3);
            tmr_pin = ~active; idle_n(3);
        end
        idle_n(3);
    endtask

    initial begin
        idle_n(3);
        rst = 1'b0;
        idle_n(1);
        // R1
        chk("R1 ctrl", ctrl_q, 8'h00);
        chk("R1 count", count_q, 8'h00);
        chk("R1 irq/wake", {6'b0, irq, wake}, 8'h00);

        // Capture table (R6, R7, R8, R9)
        for (int i = 0; i < 6; i++) begin
            logic pol;
            logic [2:0] psc;
            logic [7:0] w, p, frozen;
            pol = CAP_VEC[i][20]; psc = CAP_VEC[i][18:16];
            w = CAP_VEC[i][15:8]; p = CAP_VEC[i][7:0];
            tmr_pin = ~pol; idle_n(4);
            wr(1'b1, p);
            wr(1'b0, {2'b11, 1'b0, 1'b1, pol, psc});
            idle_n(4);
            chk("R8 armed", {7'b0, ctrl_q[4]}, 8'h01);
            tmr_pin = pol; idle_n(int'(w));
            tmr_pin = ~pol; idle_n(6);
            chk(pol ? "R7 width" : "R6 width", count_q, model(p, int'(w) >> psc));
            chk("R8 autoclear", {7'b0, ctrl_q[4]}, 8'h00);
            frozen = count_q;
            pulses(2, pol);
            chk("R9 ignored", count_q, frozen);
        end

        // R2: mode 00 with enable set holds; preload write loads
        tmr_pin = 1'b0;
        wr(1'b0, 8'h00); wr(1'b1, 8'h44);
        wr(1'b0, {2'b00, 1'b0, 1'b1, 1'b1, 3'd0});
        pulses(3, 1'b1);
        chk("R2 hold", count_q, 8'h44);
        wr(1'b1, 8'h55);
        idle_n(1);
        chk("R2 load", count_q, 8'h55);

        // R3: timer, clock source, prescale 4, 16 cycles
        clk_src = 2'b00;
        wr(1'b0, 8'h00); wr(1'b1, 8'h10);
        wr(1'b0, {2'b10, 1'b0, 1'b1, 1'b0, 3'd2});
        idle_n(15);
        chk("R8 timer keeps enable", {7'b0, ctrl_q[4]}, 8'h01);
        wr(1'b0, {2'b10, 1'b0, 1'b0, 1'b0, 3'd2});
        chk("R3 prescale", count_q, 8'h14);

        // R4: clock/4 with prescale 2, 32 cycles
        clk_src = 2'b01;
        wr(1'b1, 8'h20);
        wr(1'b0, {2'b10, 1'b0, 1'b1, 1'b0, 3'd1});
        idle_n(31);
        wr(1'b0, {2'b10, 1'b0, 1'b0, 1'b0, 3'd1});
        chk("R4 div4", count_q, 8'h24);

        // R4: slow strobe, prescale 2, six strobes
        clk_src = 2'b10;
        wr(1'b1, 8'h30);
        wr(1'b0, {2'b10, 1'b0, 1'b1, 1'b0, 3'd1});
        for (int i = 0; i < 6; i++) begin
            slow_tick = 1'b1; idle_n(1);
            slow_tick = 1'b0; idle_n(2);
        end
        wr(1'b0, {2'b10, 1'b0, 1'b0, 1'b0, 3'd1});
        chk("R4 slow", count_q, 8'h33);
        clk_src = 2'b00;

        // R5: edge counting, rising then falling
        tmr_pin = 1'b0;
        wr(1'b1, 8'h60);
        wr(1'b0, {2'b01, 1'b0, 1'b1, 1'b1, 3'd0});
        pulses(5, 1'b1);
        chk("R5 rising", count_q, 8'h65);
        wr(1'b0, {2'b01, 1'b0, 1'b1, 1'b0, 3'd0});
        pulses(3, 1'b1);
        chk("R5 falling", count_q, 8'h68);
        chk("R8 event keeps enable", {7'b0, ctrl_q[4]}, 8'h01);

        // R10, R11, R12: edge mode wraps
        wr(1'b0, 8'h00); wr(1'b1, 8'hFE);
        irq_seen = 0; wake_seen = 0; int_en = 1'b1;
        wr(1'b0, {2'b01, 1'b0, 1'b1, 1'b1, 3'd0});
        pulses(3, 1'b1);
        chk("R10 reload", count_q, 8'hFF);
        chk("R11 irq count", 8'(irq_seen), 8'd1);
        chk("R12 wake count", 8'(wake_seen), 8'd1);
        int_en = 1'b0;
        pulses(2, 1'b1);
        chk("R11 irq masked", 8'(irq_seen), 8'd1);
        chk("R12 wake unmasked", 8'(wake_seen), 8'd2);

        // R12 negative, R10: timer wraps do not wake
        wr(1'b0, 8'h00); wr(1'b1, 8'hFC);
        int_en = 1'b1;
        wr(1'b0, {2'b10, 1'b0, 1'b1, 1'b0, 3'd0});
        idle_n(9);
        wr(1'b0, {2'b10, 1'b0, 1'b0, 1'b0, 3'd0});
        int_en = 1'b0;
        idle_n(2);
        chk("R10 timer wrap", count_q, 8'hFE);
        chk("R11 timer irq", 8'(irq_seen), 8'd3);
        chk("R12 timer no wake", 8'(wake_seen), 8'd2);

        // R13: preload write while running
        wr(1'b1, 8'h00);
        wr(1'b0, {2'b10, 1'b0, 1'b1, 1'b0, 3'd0});
        idle_n(3);
        wr(1'b1, 8'hA0);
        idle_n(5);
        wr(1'b0, {2'b10, 1'b0, 1'b0, 1'b0, 3'd0});
        chk("R13 running preload", count_q, 8'h0A);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule